// File: doc/BRIEF.md
# Byte-Serial Snapshot Event Counter

This block counts external events in a 32-bit binary up counter that runs on the system clock. Two asynchronous count inputs are combined into one effective count signal, their logical AND. That signal is synchronised and then reduced to a one-cycle increment strobe on each of its high-to-low transitions. A third asynchronous input, the test strobe, goes through the same kind of path and advances only the upper half of the counter. This lets the high half be exercised quickly.

To read the value, the system first takes a snapshot of the live count into a holding register. A byte sequencer then places the snapshot on an 8-bit data bus, least significant byte first, one byte per scan strobe. A data-valid enable marks when the bus is driven. When the last byte has been scanned, the bus is released and a one-cycle cascade pulse is issued. Wiring that pulse into the cascade input of a second counter makes several counters stream their bytes back to back over one shared bus.

Top module: `byte_evt_counter`

## Requirements
- R1: Each high-to-low transition of the AND of the two count inputs adds exactly one to the count. No other change of the count inputs alters the count.
- R2: While one count input is held low, pulses on the other count input do not advance the count. While one count input is held high, falling edges on the other count input do advance it. Taking an input low while the other is high is itself one counted edge.
- R3: While the active-low reset is low, the count and the snapshot are zero, the bus is released and the cascade output is low.
- R4: A falling edge on the test strobe adds 2^(W/2) to the count, where W is the counter width. The lower half of the count is left unchanged.
- R5: An increment from all ones gives all zeros. The count does not saturate.
- R6: When the latch input is high at a clock edge, the snapshot takes the count held before that edge. Later counting does not change the snapshot until the next latch.
- R7: A start request makes the enable high after the next edge and presents byte 0, which is snapshot bits [7:0]. Byte k is snapshot bits [8k+7:8k].
- R8: While the bus is enabled, each scan strobe moves to the next byte. A scan on the last byte releases the bus and raises the cascade output for exactly one cycle.
- R9: A cascade-input pulse starts the byte sequence exactly as a start request does. A chained counter therefore begins its bytes one cycle after the previous counter releases the bus.
- R10: When the enable is low, the data bus reads all zeros.
- R11: A start request during a sequence restarts it at byte 0.
- R12: Scan strobes have no effect while the bus is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_a_i | input | 1 | First asynchronous count input |
| cnt_b_i | input | 1 | Second asynchronous count input |
| tst_cnt_i | input | 1 | Asynchronous test strobe for the upper half |
| latch_i | input | 1 | Snapshot request |
| start_i | input | 1 | Starts byte readout |
| scan_i | input | 1 | Advances to the next byte |
| casc_in_i | input | 1 | Cascade pulse from the previous counter |
| dout_o | output | 8 | Data bus, zero when released |
| doe_o | output | 1 | Bus enable |
| casc_out_o | output | 1 | One-cycle pulse after the last byte |

## Verification
The bench chains a 32-bit counter into a 16-bit one. A wrong cascade (R9) would therefore drop or duplicate bytes in the combined stream. A design with an OR where the AND belongs would count pulses on one input while the other input is held low (R2). Wrap is checked on the narrow instance with the test strobe. A saturating design would stay at all ones, and a test path that fed the low bits would corrupt the lower half (R4, R5). Other runs scan while the bus is idle, restart in the middle of a sequence and read a stale snapshot. Each of these exposes designs that advance the index when idle (R12), resume instead of restarting (R11), or re-latch implicitly (R6).

// File: rtl/evtcnt_pkg.sv
package evtcnt_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic {
    SEQ_IDLE  = 1'b0,
    SEQ_SHIFT = 1'b1
  } seq_state_e;

  function automatic int unsigned byte_lsb(input int unsigned idx);
    return idx * BYTE_W;
  endfunction
endpackage

// File: rtl/evtcnt_sync_fall.sv
module evtcnt_sync_fall #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic fall_o
);
  logic [STAGES:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= {pipe_q[STAGES-1:0], din};
  end

  // older sample high, newer sample low
  assign fall_o = pipe_q[STAGES] & ~pipe_q[STAGES-1];
endmodule

// File: rtl/evtcnt_core.sv
module evtcnt_core #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_lo_i,
  input  logic             inc_hi_i,
  input  logic             latch_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] hold_o
);
  localparam int HALF = CNT_W / 2;

  function automatic logic [CNT_W-1:0] step_of(input logic lo, input logic hi);
    logic [CNT_W-1:0] s;
    s       = '0;
    s[0]    = lo;
    s[HALF] = hi;
    return s;
  endfunction

  logic [CNT_W-1:0] cnt_q, hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      hold_q <= '0;
    end else begin
      cnt_q <= cnt_q + step_of(inc_lo_i, inc_hi_i);
      if (latch_i) hold_q <= cnt_q;
    end
  end

  assign cnt_o  = cnt_q;
  assign hold_o = hold_q;
endmodule

// File: rtl/evtcnt_seq.sv
module evtcnt_seq
  import evtcnt_pkg::*;
#(
  parameter int NBYTES = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     go_i,
  input  logic                     scan_i,
  input  logic [NBYTES*BYTE_W-1:0] hold_i,
  output logic [BYTE_W-1:0]        dout_o,
  output logic                     doe_o,
  output logic                     cout_o,
  output logic                     last_o
);
  localparam int IDX_W = (NBYTES > 1) ? $clog2(NBYTES) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NBYTES - 1);

  logic [BYTE_W-1:0] byte_arr [NBYTES];

  for (genvar g = 0; g < NBYTES; g++) begin : g_bytes
    assign byte_arr[g] = hold_i[byte_lsb(g) +: BYTE_W];
  end

  seq_state_e       st_q;
  logic [IDX_W-1:0] idx_q;
  logic             cout_q;

  assign last_o = (idx_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SEQ_IDLE;
      idx_q  <= '0;
      cout_q <= 1'b0;
    end else begin
      cout_q <= 1'b0;
      if (go_i) begin
        st_q  <= SEQ_SHIFT;
        idx_q <= '0;
      end else if (st_q == SEQ_SHIFT && scan_i) begin
        if (last_o) begin
          st_q   <= SEQ_IDLE;
          idx_q  <= '0;
          cout_q <= 1'b1;
        end else begin
          idx_q <= idx_q + IDX_W'(1);
        end
      end
    end
  end

  assign doe_o  = (st_q == SEQ_SHIFT);
  assign dout_o = doe_o ? byte_arr[idx_q] : '0;
  assign cout_o = cout_q;
endmodule

// File: rtl/byte_evt_counter.sv
module byte_evt_counter
  import evtcnt_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_a_i,
  input  logic              cnt_b_i,
  input  logic              tst_cnt_i,
  input  logic              latch_i,
  input  logic              start_i,
  input  logic              scan_i,
  input  logic              casc_in_i,
  output logic [BYTE_W-1:0] dout_o,
  output logic              doe_o,
  output logic              casc_out_o
);
  localparam int NBYTES = CNT_W / BYTE_W;

  logic             cnt_eff;
  logic             inc_lo, inc_hi;
  logic             seq_go;
  logic             last_byte;
  logic [CNT_W-1:0] cnt_w, hold_w;

  assign cnt_eff = cnt_a_i & cnt_b_i;
  assign seq_go  = start_i | casc_in_i;

  evtcnt_sync_fall #(.STAGES(SYNC_STAGES)) u_cnt_edge (
    .clk(clk), .rst_n(rst_n), .din(cnt_eff), .fall_o(inc_lo)
  );

  evtcnt_sync_fall #(.STAGES(SYNC_STAGES)) u_tst_edge (
    .clk(clk), .rst_n(rst_n), .din(tst_cnt_i), .fall_o(inc_hi)
  );

  evtcnt_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .inc_lo_i(inc_lo), .inc_hi_i(inc_hi),
    .latch_i(latch_i), .cnt_o(cnt_w), .hold_o(hold_w)
  );

  evtcnt_seq #(.NBYTES(NBYTES)) u_seq (
    .clk(clk), .rst_n(rst_n), .go_i(seq_go), .scan_i(scan_i),
    .hold_i(hold_w), .dout_o(dout_o), .doe_o(doe_o),
    .cout_o(casc_out_o), .last_o(last_byte)
  );
endmodule

// File: rtl/evtcnt_chk.sv
module evtcnt_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] hold,
  input logic             inc_lo,
  input logic             inc_hi,
  input logic             latch,
  input logic             go,
  input logic             doe,
  input logic [7:0]       dout,
  input logic             cout
);
  localparam int HALF = CNT_W / 2;

  // R1: no strobe, no change
  p_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc_lo && !inc_hi) |=> $stable(cnt));

  // R4: test strobe leaves the lower half alone
  p_test_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_hi && !inc_lo) |=> (cnt[HALF-1:0] == $past(cnt[HALF-1:0])));

  p_snap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    latch |=> (hold == $past(cnt)));

  p_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !latch |=> $stable(hold));

  p_go_r9: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> (doe && dout == hold[7:0]));

  p_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cout |=> !cout);

  p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cout |-> !doe);

  p_zero_bus_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !doe |-> (dout == 8'h00));

  p_idle_scan_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!doe && !go) |=> !doe);
endmodule

bind byte_evt_counter evtcnt_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt(cnt_w), .hold(hold_w),
  .inc_lo(inc_lo), .inc_hi(inc_hi), .latch(latch_i), .go(seq_go),
  .doe(doe_o), .dout(dout_o), .cout(casc_out_o)
);

// File: tb/byte_evt_counter_tb_top.sv
module byte_evt_counter_tb_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, ca = 1'b1, cb = 1'b1, tc = 1'b1;
  logic latch = 1'b0, start = 1'b0, scan = 1'b0;
  logic [7:0] d0, d1;
  logic oe0, oe1, co0, co1;
  logic [7:0] bus;
  assign bus = d0 | d1;

  int nchk = 0, nfail = 0;
  bit done = 0;

  byte_evt_counter dut_i (
    .clk(clk), .rst_n(rst_n), .cnt_a_i(ca), .cnt_b_i(cb), .tst_cnt_i(tc),
    .latch_i(latch), .start_i(start), .scan_i(scan), .casc_in_i(1'b0),
    .dout_o(d0), .doe_o(oe0), .casc_out_o(co0)
  );

  byte_evt_counter #(.CNT_W(16)) dut_w (
    .clk(clk), .rst_n(rst_n), .cnt_a_i(ca), .cnt_b_i(cb), .tst_cnt_i(tc),
    .latch_i(latch), .start_i(1'b0), .scan_i(scan), .casc_in_i(co0),
    .dout_o(d1), .doe_o(oe1), .casc_out_o(co1)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference, updated every edge
  logic [31:0] m_cnt [2], m_hold [2];
  logic        m_act [2], m_cout [2];
  int          m_idx [2];
  bit          eq [$], tq [$];

  always @(posedge clk) begin : mdl
    bit fe, ft, cin1, go;
    int lastb;
    logic [31:0] mask, hi;
    if (!rst_n) begin
      for (int k = 0; k < 2; k++) begin
        m_cnt[k] = 0; m_hold[k] = 0; m_act[k] = 0; m_cout[k] = 0; m_idx[k] = 0;
      end
      eq = '{0, 0, 0, 0};
      tq = '{0, 0, 0, 0};
    end else begin
      eq.push_back(ca & cb); void'(eq.pop_front());
      tq.push_back(tc);      void'(tq.pop_front());
      fe   = eq[0] & ~eq[1];
      ft   = tq[0] & ~tq[1];
      cin1 = m_cout[0];
      for (int k = 0; k < 2; k++) begin
        mask  = (k == 0) ? 32'hFFFF_FFFF : 32'h0000_FFFF;
        hi    = (k == 0) ? 32'h0001_0000 : 32'h0000_0100;
        lastb = (k == 0) ? 3 : 1;
        go    = (k == 0) ? start : cin1;
        if (latch) m_hold[k] = m_cnt[k];
        m_cnt[k] = (m_cnt[k] + (fe ? 32'd1 : 32'd0) + (ft ? hi : 32'd0)) & mask;
        if (go) begin
          m_act[k] = 1; m_idx[k] = 0; m_cout[k] = 0;
        end else if (m_act[k] && scan) begin
          if (m_idx[k] == lastb) begin
            m_act[k] = 0; m_idx[k] = 0; m_cout[k] = 1;
          end else begin
            m_idx[k]++; m_cout[k] = 0;
          end
        end else m_cout[k] = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int k = 0; k < 2; k++) begin
        logic [7:0] ed;
        ed = m_act[k] ? m_hold[k][8*m_idx[k] +: 8] : 8'h00;
        chk("R7 bus byte", (k == 0) ? d0 : d1, ed);
        chk("R10 enable", (k == 0) ? oe0 : oe1, m_act[k]);
        chk("R8 cascade out", (k == 0) ? co0 : co1, m_cout[k]);
      end
    end
  end

  // ---------------- stimulus helpers
  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulse(input bit pa, input bit pb, input bit pt, input int n);
    repeat (n) begin
      @(posedge clk); #1;
      if (pa) ca = 0;
      if (pb) cb = 0;
      if (pt) tc = 0;
      cyc(3);
      ca = 1; cb = 1; tc = 1;
      cyc(3);
    end
  endtask

  task automatic readout(input bit do_latch, output logic [31:0] v32,
                         output logic [15:0] v16);
    logic [7:0] b [6];
    int n;
    n = 0;
    for (int i = 0; i < 6; i++) b[i] = 8'h00;
    @(posedge clk); #1 latch = do_latch; start = 1;
    @(posedge clk); #1 latch = 0; start = 0;
    for (int c = 0; c < 60 && n < 6; c++) begin
      @(negedge clk);
      if (oe0 | oe1) begin
        chk("R9 single driver", oe0 & oe1, 0);
        b[n] = bus; n++;
        @(posedge clk); #1 scan = 1;
        @(posedge clk); #1 scan = 0;
      end
    end
    chk("R9 byte count", n, 6);
    v32 = {b[3], b[2], b[1], b[0]};
    v16 = {b[5], b[4]};
    cyc(3);
    @(negedge clk);
    chk("R10 idle bus", {oe0, oe1, bus}, 0);
  endtask

  logic [31:0] e32, r32;
  logic [15:0] e16, r16;

  task automatic add(input int lo, input int hi);
    e32 = e32 + 32'(lo) + (32'(hi) << 16);
    e16 = e16 + 16'(lo) + (16'(hi) << 8);
  endtask

  task automatic expect_both(input string tag);
    chk({tag, " wide"}, r32, e32);
    chk({tag, " narrow R9"}, r16, e16);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
      $finish;
    end
  end

  initial begin
    e32 = 0; e16 = 0;
    cyc(4);
    @(negedge clk);
    chk("R3 reset bus", {oe0, oe1, co0, co1, bus}, 0);
    @(posedge clk); #1 rst_n = 1;
    cyc(3);

    // R3: fresh count reads zero
    readout(1, r32, r16); expect_both("R3 after reset");

    // R1: pulses on either input
    pulse(1, 0, 0, 5); add(5, 0);
    readout(1, r32, r16); expect_both("R1 five on a");
    pulse(0, 1, 0, 3); add(3, 0);
    readout(1, r32, r16); expect_both("R1 three on b");

    // R2: b held low blocks a; lowering b is one edge
    cb = 0; add(1, 0); cyc(4);
    repeat (4) begin ca = 0; cyc(3); ca = 1; cyc(3); end
    cb = 1; cyc(5);
    readout(1, r32, r16); expect_both("R2 blocked input");

    // R4: test strobe into upper half
    pulse(0, 0, 1, 2); add(0, 2);
    readout(1, r32, r16); expect_both("R4 test strobe");

    // R6: snapshot stays until relatched
    pulse(1, 0, 0, 3);
    readout(0, r32, r16); expect_both("R6 stale snapshot");
    add(3, 0);
    readout(1, r32, r16); expect_both("R6 relatched");

    // R11: restart mid-sequence
    start = 1; cyc(1); start = 0; scan = 1; cyc(1); scan = 0;
    @(negedge clk); chk("R11 second byte", bus, e32[15:8]);
    @(posedge clk); #1 start = 1; cyc(1); start = 0;
    @(negedge clk); chk("R11 restart byte0", bus, e32[7:0]);
    @(posedge clk); #1 scan = 1; cyc(10); scan = 0; cyc(2);

    // R12: scans while idle do nothing
    scan = 1; cyc(3); scan = 0;
    start = 1; cyc(1); start = 0;
    @(negedge clk); chk("R12 byte0 after idle scans", {oe0, bus}, {1'b1, e32[7:0]});
    @(posedge clk); #1 scan = 1; cyc(10); scan = 0; cyc(2);

    // R3: reset mid-run clears the count
    rst_n = 0; cyc(2);
    @(negedge clk); chk("R3 bus in reset", {oe0, oe1, bus}, 0);
    @(posedge clk); #1 rst_n = 1; cyc(2);
    e32 = 0; e16 = 0;
    readout(1, r32, r16); expect_both("R3 cleared");

    // R5: wrap on the narrow instance
    pulse(1, 0, 1, 255); add(255, 255);
    readout(1, r32, r16); expect_both("R5 all ones");
    chk("R5 narrow full", r16, 16'hFFFF);
    pulse(1, 0, 0, 1); add(1, 0);
    readout(1, r32, r16); expect_both("R5 wrapped");
    chk("R5 narrow zero", r16, 16'h0000);
    chk("R4 carry wide", r32, 32'h00FF_0100);

    cyc(4);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end
endmodule